// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder with Refresh Row Counter

This block sits on the device side of an asynchronous DRAM's control pins. It samples the active-low row strobe, column strobe, write enable and output enable on every clock. From the order in which these strobes change, it works out what kind of cycle the memory controller is running. When the row strobe falls, the levels of the other strobes decide between a normal access, a strobe-ordered refresh, or an entry into compressed test mode. A normal access becomes a read, a write or a refresh of an external row only later, when the column strobe falls or when the row strobe rises first.

Every recognised cycle is reported as a one-clock pulse with a cycle kind and the row that the array should activate. Refreshes whose row is not taken from the address pins use an internal wrapping row counter. A timer watches refresh cycles in which both strobes are held low. After a parameterised number of clocks it enters self refresh. From then on it issues internal refreshes at a fixed parameterised interval until the row strobe returns high. The block also provides a test-mode flag and the enable for the data output drivers.

Top module: `dram_cycle_ctrl`

## Requirements
- R1: After reset, cyc_pulse, test_mode, self_ref and dq_oe are 0, and the first counter-based refresh reports row 0.
- R2: A row strobe fall with column strobe high latches addr as the row. Each later column strobe fall in that cycle reports kind 1 (read) if we_n is high or kind 2 (write) if we_n is low, with the latched row. Repeated column strobes in one row cycle (page mode) report once each.
- R3: If the row strobe rises again before any column strobe fall, kind 3 (external-row refresh) is reported with the latched row after the rise.
- R4: A row strobe fall while the column strobe is low and we_n is high reports kind 4 (counter refresh) with the counter row. The counter then advances by one, wrapping from 4095 to 0.
- R5: If the column strobe has stayed low since the row strobe rise of a preceding access cycle, such a refresh reports kind 5 (hidden refresh) instead and uses the same counter.
- R6: dq_oe is 1 only after a read has been classified, while the column strobe and oe_n are both low. It drops in the same cycle that either strobe goes high, and it stays high through a hidden refresh.
- R7: A row strobe fall with both the column strobe and we_n low, while addr[9:0] is all ones, sets test_mode and reports kind 7 with addr as the row. addr[11:10] have no effect on entry.
- R8: The same strobe pattern while test_mode is set, or with any of addr[9:0] low, is a counter refresh (kind 4). It leaves test_mode unchanged.
- R9: A counter refresh, hidden refresh or external-row refresh clears test_mode.
- R10: If the row and column strobes both stay low for SELF_TICKS clocks after a kind 4 or kind 5 refresh starts, self_ref is set and a kind 6 pulse reports the counter row. A column strobe rise before that cancels entry.
- R11: While self_ref is set, a kind 6 pulse with the next counter row is issued every REF_INTERVAL clocks. self_ref clears when the row strobe goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 12 | Multiplexed address pins |
| cyc_pulse | output | 1 | One-clock pulse for each recognised cycle |
| cyc_kind | output | 3 | Cycle kind, valid with cyc_pulse |
| cyc_row | output | 12 | Row to activate, valid with cyc_pulse |
| test_mode | output | 1 | Compressed test mode active |
| self_ref | output | 1 | Self refresh active |
| dq_oe | output | 1 | Data output driver enable |

## Verification
The embedded properties check several rules on every clock. Consecutive counter-based refreshes must report consecutive rows. Test mode may only start after a sampled write-enabled strobe-ordered refresh with the low ten address bits set. An external-row refresh is reported only after a sampled row strobe rise. Self refresh is entered only with both strobes low, and it never persists once the row strobe is sampled high. Some behaviours need a scoreboard of intended cycles to show: that each strobe ordering produces the right kind and row, that page-mode accesses repeat, the counter wrap at 4095, test-mode exit on each refresh kind, cancellation of self refresh when the column strobe rises, and the data enable holding through a hidden refresh.

// File: rtl/dram_cyc_pkg.sv
package dram_cyc_pkg;

    typedef enum logic [2:0] {
        KIND_NONE    = 3'd0,
        KIND_READ    = 3'd1,
        KIND_WRITE   = 3'd2,
        KIND_RASONLY = 3'd3,
        KIND_CBR     = 3'd4,
        KIND_HIDDEN  = 3'd5,
        KIND_SELF    = 3'd6,
        KIND_TEST    = 3'd7
    } cyc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PEND   = 3'd1,
        ST_ACCESS = 3'd2,
        ST_REFR   = 3'd3,
        ST_SELF   = 3'd4,
        ST_HOLD   = 3'd5
    } ctl_state_e;

endpackage

// File: rtl/dram_row_ctr.sv
module dram_row_ctr #(
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [ROW_W-1:0] row
);
    logic [ROW_W-1:0] row_d, row_q;

    always_comb begin
        row_d = row_q;
        if (inc) row_d = row_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) row_q <= '0;
        else        row_q <= row_d;
    end

    assign row = row_q;
endmodule

// File: rtl/dram_span_timer.sv
module dram_span_timer #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [CNT_W-1:0] limit,
    output logic             hit
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)     cnt_d = '0;
        else if (en) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hit = en && (cnt_q == limit - 1'b1);

    AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr) |-> (cnt_q < limit)) else $error("timer ran past limit"); // R10
endmodule

// File: rtl/dram_cycle_ctrl.sv
module dram_cycle_ctrl
    import dram_cyc_pkg::*;
#(
    parameter int ROW_W        = 12,
    parameter int TEST_BITS    = 10,
    parameter int SELF_TICKS   = 5000,
    parameter int REF_INTERVAL = 781
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [ROW_W-1:0] addr,
    output logic             cyc_pulse,
    output logic [2:0]       cyc_kind,
    output logic [ROW_W-1:0] cyc_row,
    output logic             test_mode,
    output logic             self_ref,
    output logic             dq_oe
);
    localparam int TMR_MAX = (SELF_TICKS > REF_INTERVAL) ? SELF_TICKS : REF_INTERVAL;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam logic [TMR_W-1:0] LIM_SELF = TMR_W'(SELF_TICKS);
    localparam logic [TMR_W-1:0] LIM_INTV = TMR_W'(REF_INTERVAL);

    typedef struct packed {
        ctl_state_e       st;
        logic             ras_p;
        logic             cas_p;
        logic [ROW_W-1:0] row;
        logic             test;
        logic             self_on;
        logic             cas_held;
        logic             rd_hold;
        logic             pulse;
        cyc_kind_e        kind;
        logic [ROW_W-1:0] orow;
    } ctl_t;

    ctl_t d, q;

    logic [ROW_W-1:0] ref_row;
    logic             ref_inc;
    logic             tmr_clr, tmr_en, tmr_sel_intv, tmr_hit;
    logic [TMR_W-1:0] tmr_lim;

    dram_row_ctr #(.ROW_W(ROW_W)) u_row_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (ref_inc),
        .row   (ref_row)
    );

    assign tmr_lim = tmr_sel_intv ? LIM_INTV : LIM_SELF;

    dram_span_timer #(.CNT_W(TMR_W)) u_span_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .en    (tmr_en),
        .limit (tmr_lim),
        .hit   (tmr_hit)
    );

    logic ras_fall, ras_rise, cas_fall;
    assign ras_fall = q.ras_p && !ras_n;
    assign ras_rise = !q.ras_p && ras_n;
    assign cas_fall = q.cas_p && !cas_n;

    always_comb begin
        d            = q;
        d.pulse      = 1'b0;
        d.kind       = KIND_NONE;
        d.ras_p      = ras_n;
        d.cas_p      = cas_n;
        ref_inc      = 1'b0;
        tmr_clr      = 1'b0;
        tmr_en       = 1'b0;
        tmr_sel_intv = 1'b0;

        if (cas_n) begin
            d.cas_held = 1'b0;
            d.rd_hold  = 1'b0;
        end

        unique case (q.st)
            ST_IDLE: begin
                if (ras_fall) begin
                    if (!cas_n && !we_n) begin
                        d.st    = ST_HOLD;
                        d.pulse = 1'b1;
                        if (!q.test && (&addr[TEST_BITS-1:0])) begin
                            d.test = 1'b1;
                            d.kind = KIND_TEST;
                            d.orow = addr;
                        end else begin
                            d.kind  = KIND_CBR;
                            d.orow  = ref_row;
                            ref_inc = 1'b1;
                        end
                    end else if (!cas_n) begin
                        d.st    = ST_REFR;
                        d.pulse = 1'b1;
                        d.kind  = q.cas_held ? KIND_HIDDEN : KIND_CBR;
                        d.orow  = ref_row;
                        d.test  = 1'b0;
                        ref_inc = 1'b1;
                        tmr_clr = 1'b1;
                    end else begin
                        d.st  = ST_PEND;
                        d.row = addr;
                    end
                end
            end
            ST_PEND: begin
                if (ras_rise) begin
                    d.st    = ST_IDLE;
                    d.pulse = 1'b1;
                    d.kind  = KIND_RASONLY;
                    d.orow  = q.row;
                    d.test  = 1'b0;
                end else if (cas_fall) begin
                    d.st      = ST_ACCESS;
                    d.pulse   = 1'b1;
                    d.kind    = we_n ? KIND_READ : KIND_WRITE;
                    d.orow    = q.row;
                    d.rd_hold = we_n;
                end
            end
            ST_ACCESS: begin
                if (ras_rise) begin
                    d.st       = ST_IDLE;
                    d.cas_held = !cas_n;
                end else if (cas_fall) begin
                    d.pulse   = 1'b1;
                    d.kind    = we_n ? KIND_READ : KIND_WRITE;
                    d.orow    = q.row;
                    d.rd_hold = we_n;
                end
            end
            ST_REFR: begin
                if (ras_rise) begin
                    d.st = ST_IDLE;
                end else if (cas_n) begin
                    d.st = ST_HOLD;
                end else begin
                    tmr_en = 1'b1;
                    if (tmr_hit) begin
                        d.st      = ST_SELF;
                        d.self_on = 1'b1;
                        d.pulse   = 1'b1;
                        d.kind    = KIND_SELF;
                        d.orow    = ref_row;
                        ref_inc   = 1'b1;
                        tmr_clr   = 1'b1;
                    end
                end
            end
            ST_SELF: begin
                if (ras_rise) begin
                    d.st      = ST_IDLE;
                    d.self_on = 1'b0;
                end else begin
                    tmr_en       = 1'b1;
                    tmr_sel_intv = 1'b1;
                    if (tmr_hit) begin
                        d.pulse = 1'b1;
                        d.kind  = KIND_SELF;
                        d.orow  = ref_row;
                        ref_inc = 1'b1;
                        tmr_clr = 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (ras_rise) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st       <= ST_IDLE;
            q.ras_p    <= 1'b1;
            q.cas_p    <= 1'b1;
            q.row      <= '0;
            q.test     <= 1'b0;
            q.self_on  <= 1'b0;
            q.cas_held <= 1'b0;
            q.rd_hold  <= 1'b0;
            q.pulse    <= 1'b0;
            q.kind     <= KIND_NONE;
            q.orow     <= '0;
        end else begin
            q <= d;
        end
    end

    assign cyc_pulse = q.pulse;
    assign cyc_kind  = q.kind;
    assign cyc_row   = q.orow;
    assign test_mode = q.test;
    assign self_ref  = q.self_on;
    assign dq_oe     = q.rd_hold && !cas_n && !oe_n;

    // Checker state: last row reported by a counter-based refresh
    logic             chk_seen_q;
    logic [ROW_W-1:0] chk_last_q;
    logic             chk_is_ref;
    assign chk_is_ref = q.pulse && (q.kind == KIND_CBR || q.kind == KIND_HIDDEN
                                    || q.kind == KIND_SELF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_seen_q <= 1'b0;
            chk_last_q <= '0;
        end else if (chk_is_ref) begin
            chk_seen_q <= 1'b1;
            chk_last_q <= q.orow;
        end
    end

    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_is_ref && chk_seen_q) |-> (q.orow == chk_last_q + 1'b1)) else $error("refresh row skipped"); // R4
    AST_TEST_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_mode) |-> $past(!cas_n && !we_n && (&addr[TEST_BITS-1:0]))) else $error("bad test entry"); // R7
    AST_RASONLY_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_pulse && cyc_kind == KIND_RASONLY) |-> $past(ras_n)) else $error("external refresh before rise"); // R3
    AST_SELF_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(self_ref) |-> $past(!cas_n && !ras_n)) else $error("self refresh without low strobes"); // R10
    AST_SELF_RAS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        self_ref |-> !q.ras_p) else $error("self refresh with row strobe high"); // R11
endmodule

// File: tb/dram_cycle_ctrl_tb.sv
module dram_cycle_ctrl_tb;
    import dram_cyc_pkg::*;

    localparam int ST = 5000;
    localparam int RI = 781;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [11:0] addr = '0;
    logic        cyc_pulse, test_mode, self_ref, dq_oe;
    logic [2:0]  cyc_kind;
    logic [11:0] cyc_row;

    dram_cycle_ctrl #(.ROW_W(12), .TEST_BITS(10), .SELF_TICKS(ST), .REF_INTERVAL(RI)) u_dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .cyc_pulse(cyc_pulse), .cyc_kind(cyc_kind), .cyc_row(cyc_row),
        .test_mode(test_mode), .self_ref(self_ref), .dq_oe(dq_oe)
    );

    int checks = 0;
    int errors = 0;
    int exp_cnt = 0;
    logic [2:0]  qk[$];
    logic [11:0] qr[$];
    string       qt[$];
    logic [2:0]  ek;
    logic [11:0] er;
    string       et;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [2:0] k, input logic [11:0] r, input string tag);
        qk.push_back(k); qr.push_back(r); qt.push_back(tag);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops the next intended cycle whenever the design reports one
    always @(negedge clk) begin
        if (rst_n && cyc_pulse) begin
            if (qk.size() == 0) begin
                chk(1'b0, "unexpected pulse", {cyc_kind, cyc_row}, 0);
            end else begin
                ek = qk.pop_front(); er = qr.pop_front(); et = qt.pop_front();
                chk(cyc_kind == ek && cyc_row == er, et, {cyc_kind, cyc_row}, {ek, er});
            end
        end
    end

    task automatic cbr_cyc(input string tag);
        cas_n = 1'b0; step(1);
        push(KIND_CBR, 12'(exp_cnt), tag); exp_cnt = (exp_cnt + 1) % 4096;
        ras_n = 1'b0; step(2);
        ras_n = 1'b1; step(1);
        cas_n = 1'b1; step(1);
    endtask

    task automatic wcbr(input logic [11:0] a, input bit entry, input string tag);
        addr = a; cas_n = 1'b0; we_n = 1'b0; step(1);
        if (entry) push(KIND_TEST, a, tag);
        else begin
            push(KIND_CBR, 12'(exp_cnt), tag); exp_cnt = (exp_cnt + 1) % 4096;
        end
        ras_n = 1'b0; step(2);
        ras_n = 1'b1; step(1);
        cas_n = 1'b1; we_n = 1'b1; step(1);
    endtask

    task automatic ror(input logic [11:0] a, input string tag);
        addr = a; ras_n = 1'b0; step(2);
        push(KIND_RASONLY, a, tag);
        ras_n = 1'b1; step(2);
    endtask

    task automatic read_open(input logic [11:0] a, input string tag);
        addr = a; ras_n = 1'b0; step(1);
        push(KIND_READ, a, tag);
        we_n = 1'b1; oe_n = 1'b0; cas_n = 1'b0; step(2);
    endtask

    task automatic hidden(input string tag);
        read_open(12'h3C5, tag);
        ras_n = 1'b1; step(2);
        chk(dq_oe == 1'b1, "R6 dq_oe held after row strobe rise", dq_oe, 1);
        push(KIND_HIDDEN, 12'(exp_cnt), tag); exp_cnt = (exp_cnt + 1) % 4096;
        ras_n = 1'b0; step(2);
        chk(dq_oe == 1'b1, "R6 dq_oe held in hidden refresh", dq_oe, 1);
        ras_n = 1'b1; step(1);
        cas_n = 1'b1; oe_n = 1'b1; step(1);
        chk(dq_oe == 1'b0, "R6 dq_oe off after column strobe rise", dq_oe, 0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        step(3);
        chk(cyc_pulse == 0 && test_mode == 0 && self_ref == 0 && dq_oe == 0,
            "R1 reset outputs", {cyc_pulse, test_mode, self_ref, dq_oe}, 0);
        rst_n = 1'b1; step(2);

        // R2 read, OE gating, page-mode write
        read_open(12'h123, "R2 read row");
        chk(dq_oe == 1'b1, "R6 dq_oe on during read", dq_oe, 1);
        oe_n = 1'b1; step(1);
        chk(dq_oe == 1'b0, "R6 dq_oe off with oe_n high", dq_oe, 0);
        oe_n = 1'b0; step(1);
        chk(dq_oe == 1'b1, "R6 dq_oe back on", dq_oe, 1);
        cas_n = 1'b1; step(1);
        chk(dq_oe == 1'b0, "R6 dq_oe off with cas_n high", dq_oe, 0);
        push(KIND_WRITE, 12'h123, "R2 page write");
        we_n = 1'b0; cas_n = 1'b0; step(2);
        chk(dq_oe == 1'b0, "R6 dq_oe off for write", dq_oe, 0);
        cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; ras_n = 1'b1; step(2);

        cbr_cyc("R1 R4 first refresh row 0");
        cbr_cyc("R4 counter advance");
        ror(12'hABC, "R3 external row refresh");

        // Test mode entry, refresh inside, exits
        wcbr(12'h7FF, 1'b1, "R7 test entry");
        chk(test_mode == 1'b1, "R7 test_mode set", test_mode, 1);
        wcbr(12'h3FF, 1'b0, "R8 wcbr refresh in test mode");
        chk(test_mode == 1'b1, "R8 test_mode kept", test_mode, 1);
        cbr_cyc("R9 refresh exits test");
        chk(test_mode == 1'b0, "R9 exit by counter refresh", test_mode, 0);
        wcbr(12'hDFE, 1'b0, "R8 wcbr with low bit clear");
        chk(test_mode == 1'b0, "R8 no entry", test_mode, 0);
        wcbr(12'hBFF, 1'b1, "R7 entry upper bits ignored");
        ror(12'h055, "R9 R3 external refresh");
        chk(test_mode == 1'b0, "R9 exit by external refresh", test_mode, 0);
        wcbr(12'h3FF, 1'b1, "R7 entry again");
        hidden("R5 hidden refresh");
        chk(test_mode == 1'b0, "R9 exit by hidden refresh", test_mode, 0);

        // R10 cancelled self refresh
        cas_n = 1'b0; step(1);
        push(KIND_CBR, 12'(exp_cnt), "R10 cbr before cancel"); exp_cnt = (exp_cnt + 1) % 4096;
        ras_n = 1'b0; step(50);
        cas_n = 1'b1; step(ST + 20);
        chk(self_ref == 1'b0, "R10 cancel by column strobe rise", self_ref, 0);
        ras_n = 1'b1; step(2);

        // R10/R11 self refresh
        cas_n = 1'b0; step(1);
        push(KIND_CBR, 12'(exp_cnt), "R10 cbr before self"); exp_cnt = (exp_cnt + 1) % 4096;
        ras_n = 1'b0; step(100);
        chk(self_ref == 1'b0, "R10 not yet in self refresh", self_ref, 0);
        push(KIND_SELF, 12'(exp_cnt), "R10 self entry row"); exp_cnt = (exp_cnt + 1) % 4096;
        step(ST);
        chk(self_ref == 1'b1, "R10 self refresh entered", self_ref, 1);
        for (int i = 0; i < 2; i++) begin
            push(KIND_SELF, 12'(exp_cnt), "R11 interval refresh"); exp_cnt = (exp_cnt + 1) % 4096;
        end
        step(2 * RI + 5);
        ras_n = 1'b1; step(2);
        chk(self_ref == 1'b0, "R11 exit on row strobe rise", self_ref, 0);
        cas_n = 1'b1; step(2);

        // R4 wrap
        while (exp_cnt != 4095) cbr_cyc("R4 sweep");
        cbr_cyc("R4 row 4095");
        cbr_cyc("R4 wrap to 0");

        step(5);
        chk(qk.size() == 0, "R2 all intended cycles reported", qk.size(), 0);
        summary();
        $finish;
    end
endmodule